// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is the configuration and status register file of a processor core module. It sits on a simple word-addressed bus with separate read and write strobes. It holds clock configuration words, memory configuration words, a guard register that protects the clock words, a control word, and two general-purpose flag words. It also holds a small local interrupt unit, whose only source is a software-raised bit, with separate IRQ and FIQ enable masks. Every flag and enable word changes through a pair of addresses: writing ones at the first address sets those bits, and writing ones at the second clears them.

The word address has seven bits. When bit 6 is 0, the lower six bits select a register. When bit 6 is 1, the lower six bits index a read-only table of memory-module description bytes. One entry of that table reports the installed memory size, which is set by a parameter. Read data is registered. The block drives four outputs: a one-cycle reset request pulse, a remap level that hides the boot flash at address zero, a status LED level, and registered IRQ and FIQ request lines.

Top module: `cm_regbank`

## Requirements
- R1: After reset the registers read as follows: clock word 0x01000048, auxiliary clock word 0x0007FEFF, memory timing word 0x00011122, memory init word 0x00000112. The guard, control, flag, enable and software-interrupt state all read zero, and every output is low.
- R2: A write to the guard register (word 5) keeps the low 16 bits of the written data. A read returns those 16 bits, with bit 16 set exactly when they equal the key 0xA05F.
- R3: A write to the clock word (word 0) or the auxiliary clock word (word 7) takes effect only while the guard holds 0xA05F; otherwise it is ignored. The memory timing word (word 8) and the memory init word (word 9) accept every write.
- R4: The control word (word 3) stores only bit 0 (LED) and bit 2 (remap). All other bits read 0. Output `led_o` follows bit 0 and `remap_o` follows bit 2.
- R5: Writing a 1 to control bit 3 makes `soft_rst_o` high for exactly the cycle after the write. Bit 3 never reads back as 1.
- R6: Writing to word 12 ORs the data into the flag word and writing to word 13 clears the bits that are 1 in the data. The non-volatile flag word works the same way at words 14 and 15. Each flag word reads at its even word.
- R7: The IRQ enable mask is set at word 18 and cleared at word 19, and reads at word 18. The FIQ enable mask is set at word 26 and cleared at word 27, and reads at word 26.
- R8: The software interrupt is level bit 0 only. Writing bit 0 at word 20 sets it and writing bit 0 at word 21 clears it; other data bits have no effect. The level reads at words 20, 17 and 25.
- R9: IRQ status (word 16) reads level AND IRQ mask. FIQ status (word 24) reads level AND FIQ mask.
- R10: `irq_o` and `fiq_o` are registered. Each is high one cycle after (level AND its mask) is nonzero.
- R11: A read with address bit 6 set returns, zero-extended, the table byte selected by address bits 5:0. Bytes 0 to 30 are fixed, byte 31 encodes the memory size (2, 4, 16, 32 or 64 for at least 0, 32, 64, 128 or 256 MB), and bytes 32 to 63 are zero.
- R12: Reads from unmapped register words, including the voltage words 32 to 35, return zero. Writes to them change nothing.
- R13: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 7 | Word address; bit 6 selects the description table |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| soft_rst_o | output | 1 | One-cycle reset request |
| remap_o | output | 1 | High when boot flash is hidden at address zero |
| led_o | output | 1 | Status LED level |
| irq_o | output | 1 | Registered IRQ request |
| fiq_o | output | 1 | Registered FIQ request |

## Verification
The hardest situation to reach is a change to the clock word. It needs the guard to be opened first, and the result only shows on a later read. The stimulus writes the word while the guard is closed and reads it back unchanged. It then writes the key, repeats the write, and closes the guard again with a write whose upper bits match the key pattern but whose low half does not. The interrupt outputs are reached the same way: the masks are armed first, then the software bit is raised. The test also checks that data bits other than bit 0 leave the level alone.

// File: rtl/cm_regbank_pkg.sv
package cm_regbank_pkg;
  localparam int WORD_W = 6;
  localparam int ADDR_W = WORD_W + 1;
  localparam int DATA_W = 32;
  localparam int TBL_DEPTH = 1 << WORD_W;

  typedef logic [WORD_W-1:0] word_idx_t;

  localparam word_idx_t W_OSC   = 6'd0;
  localparam word_idx_t W_CTRL  = 6'd3;
  localparam word_idx_t W_LOCK  = 6'd5;
  localparam word_idx_t W_AUX   = 6'd7;
  localparam word_idx_t W_SDRAM = 6'd8;
  localparam word_idx_t W_INIT  = 6'd9;
  localparam word_idx_t W_FLG   = 6'd12;
  localparam word_idx_t W_FLGC  = 6'd13;
  localparam word_idx_t W_NVF   = 6'd14;
  localparam word_idx_t W_NVFC  = 6'd15;
  localparam word_idx_t W_ISTAT = 6'd16;
  localparam word_idx_t W_IRAW  = 6'd17;
  localparam word_idx_t W_IEN   = 6'd18;
  localparam word_idx_t W_IENC  = 6'd19;
  localparam word_idx_t W_SOFT  = 6'd20;
  localparam word_idx_t W_SOFTC = 6'd21;
  localparam word_idx_t W_FSTAT = 6'd24;
  localparam word_idx_t W_FRAW  = 6'd25;
  localparam word_idx_t W_FEN   = 6'd26;
  localparam word_idx_t W_FENC  = 6'd27;

  localparam logic [15:0]       GUARD_KEY = 16'hA05F;
  localparam logic [DATA_W-1:0] OSC_RST   = 32'h0100_0048;
  localparam logic [DATA_W-1:0] AUX_RST   = 32'h0007_FEFF;
  localparam logic [DATA_W-1:0] SDRAM_RST = 32'h0001_1122;
  localparam logic [DATA_W-1:0] INIT_RST  = 32'h0000_0112;

  localparam int CTL_LED = 0;
  localparam int CTL_REMAP = 2;
  localparam int CTL_RESET = 3;

  function automatic logic [7:0] size_code(input int mem_mb);
    if (mem_mb >= 256)      return 8'd64;
    else if (mem_mb >= 128) return 8'd32;
    else if (mem_mb >= 64)  return 8'd16;
    else if (mem_mb >= 32)  return 8'd4;
    else                    return 8'd2;
  endfunction

  function automatic logic [7:0] tbl_byte(input word_idx_t idx, input int mem_mb);
    case (idx)
      6'd0:  return 8'd128;
      6'd1:  return 8'd8;
      6'd2:  return 8'd4;
      6'd3:  return 8'd11;
      6'd4:  return 8'd9;
      6'd5:  return 8'd1;
      6'd6:  return 8'd64;
      6'd8:  return 8'd2;
      6'd9:  return 8'hA0;
      6'd10: return 8'hA0;
      6'd13: return 8'd8;
      6'd15: return 8'd1;
      6'd16: return 8'h0E;
      6'd17: return 8'd4;
      6'd18: return 8'h1C;
      6'd19: return 8'd1;
      6'd20: return 8'd2;
      6'd21: return 8'h20;
      6'd22: return 8'hC0;
      6'd27: return 8'h30;
      6'd28: return 8'h28;
      6'd29: return 8'h30;
      6'd30: return 8'h28;
      6'd31: return size_code(mem_mb);
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/cm_rst_sync.sv
module cm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sync_q[STAGES-1];
endmodule

// File: rtl/cm_cfg_regs.sv
module cm_cfg_regs
  import cm_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  word_idx_t         wr_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] osc_q,
  output logic [DATA_W-1:0] aux_q,
  output logic [DATA_W-1:0] sdram_q,
  output logic [DATA_W-1:0] init_q,
  output logic [15:0]       guard_q,
  output logic              unlocked
);
  logic              guard_en, osc_en, aux_en, sdram_en, init_en;
  logic [15:0]       guard_d;

  assign unlocked = (guard_q == GUARD_KEY);

  always_comb begin
    guard_en = wr_en && (wr_word == W_LOCK);
    osc_en   = wr_en && (wr_word == W_OSC) && unlocked;
    aux_en   = wr_en && (wr_word == W_AUX) && unlocked;
    sdram_en = wr_en && (wr_word == W_SDRAM);
    init_en  = wr_en && (wr_word == W_INIT);
    guard_d  = wdata[15:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      guard_q <= '0;
      osc_q   <= OSC_RST;
      aux_q   <= AUX_RST;
      sdram_q <= SDRAM_RST;
      init_q  <= INIT_RST;
    end else begin
      if (guard_en) guard_q <= guard_d;
      if (osc_en)   osc_q   <= wdata;
      if (aux_en)   aux_q   <= wdata;
      if (sdram_en) sdram_q <= wdata;
      if (init_en)  init_q  <= wdata;
    end
  end
endmodule

// File: rtl/cm_ctrl_flags.sv
module cm_ctrl_flags
  import cm_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  word_idx_t         wr_word,
  input  logic [DATA_W-1:0] wdata,
  output logic              led_q,
  output logic              remap_q,
  output logic              rst_req_q,
  output logic [DATA_W-1:0] flags_q,
  output logic [DATA_W-1:0] nvflags_q
);
  logic              ctrl_en, flags_en, nv_en;
  logic              rst_req_d;
  logic [DATA_W-1:0] flags_d, nvflags_d;

  always_comb begin
    ctrl_en   = wr_en && (wr_word == W_CTRL);
    rst_req_d = ctrl_en && wdata[CTL_RESET];
    flags_en  = wr_en && ((wr_word == W_FLG) || (wr_word == W_FLGC));
    nv_en     = wr_en && ((wr_word == W_NVF) || (wr_word == W_NVFC));
    flags_d   = (wr_word == W_FLG) ? (flags_q | wdata) : (flags_q & ~wdata);
    nvflags_d = (wr_word == W_NVF) ? (nvflags_q | wdata) : (nvflags_q & ~wdata);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      rst_req_q <= 1'b0;
      flags_q   <= '0;
      nvflags_q <= '0;
    end else begin
      rst_req_q <= rst_req_d;
      if (ctrl_en) begin
        led_q   <= wdata[CTL_LED];
        remap_q <= wdata[CTL_REMAP];
      end
      if (flags_en) flags_q   <= flags_d;
      if (nv_en)    nvflags_q <= nvflags_d;
    end
  end
endmodule

// File: rtl/cm_local_intc.sv
module cm_local_intc
  import cm_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  word_idx_t         wr_word,
  input  logic [DATA_W-1:0] wdata,
  output logic              soft_q,
  output logic [DATA_W-1:0] irq_en_q,
  output logic [DATA_W-1:0] fiq_en_q,
  output logic [DATA_W-1:0] level,
  output logic              irq_q,
  output logic              fiq_q
);
  logic              soft_en, ien_en, fen_en;
  logic              soft_d, irq_d, fiq_d;
  logic [DATA_W-1:0] irq_en_d, fiq_en_d;

  assign level = {{(DATA_W-1){1'b0}}, soft_q};

  always_comb begin
    soft_en  = wr_en && wdata[0] && ((wr_word == W_SOFT) || (wr_word == W_SOFTC));
    soft_d   = (wr_word == W_SOFT);
    ien_en   = wr_en && ((wr_word == W_IEN) || (wr_word == W_IENC));
    fen_en   = wr_en && ((wr_word == W_FEN) || (wr_word == W_FENC));
    irq_en_d = (wr_word == W_IEN) ? (irq_en_q | wdata) : (irq_en_q & ~wdata);
    fiq_en_d = (wr_word == W_FEN) ? (fiq_en_q | wdata) : (fiq_en_q & ~wdata);
    irq_d    = |(level & irq_en_q);
    fiq_d    = |(level & fiq_en_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      soft_q   <= 1'b0;
      irq_en_q <= '0;
      fiq_en_q <= '0;
      irq_q    <= 1'b0;
      fiq_q    <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
      if (soft_en) soft_q   <= soft_d;
      if (ien_en)  irq_en_q <= irq_en_d;
      if (fen_en)  fiq_en_q <= fiq_en_d;
    end
  end
endmodule

// File: rtl/cm_regbank.sv
module cm_regbank
  import cm_regbank_pkg::*;
#(
  parameter int MEM_MB = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              soft_rst_o,
  output logic              remap_o,
  output logic              led_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic              rst_ni;
  logic              in_tbl, reg_wr;
  word_idx_t         word;
  logic [DATA_W-1:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q;
  logic [DATA_W-1:0] irq_en_q, fiq_en_q, level;
  logic [15:0]       guard_q;
  logic              unlocked, soft_q;
  logic [DATA_W-1:0] rd_d, rdata_q;

  assign in_tbl = bus_addr[ADDR_W-1];
  assign word   = bus_addr[WORD_W-1:0];
  assign reg_wr = bus_wr && !in_tbl;

  cm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ni(rst_ni)
  );

  cm_cfg_regs u_cfg (
    .clk(clk), .rst_ni(rst_ni), .wr_en(reg_wr), .wr_word(word), .wdata(bus_wdata),
    .osc_q(osc_q), .aux_q(aux_q), .sdram_q(sdram_q), .init_q(init_q),
    .guard_q(guard_q), .unlocked(unlocked)
  );

  cm_ctrl_flags u_ctl (
    .clk(clk), .rst_ni(rst_ni), .wr_en(reg_wr), .wr_word(word), .wdata(bus_wdata),
    .led_q(led_o), .remap_q(remap_o), .rst_req_q(soft_rst_o),
    .flags_q(flags_q), .nvflags_q(nvflags_q)
  );

  cm_local_intc u_intc (
    .clk(clk), .rst_ni(rst_ni), .wr_en(reg_wr), .wr_word(word), .wdata(bus_wdata),
    .soft_q(soft_q), .irq_en_q(irq_en_q), .fiq_en_q(fiq_en_q), .level(level),
    .irq_q(irq_o), .fiq_q(fiq_o)
  );

  always_comb begin
    rd_d = '0;
    if (in_tbl) begin
      rd_d[7:0] = tbl_byte(word, MEM_MB);
    end else begin
      case (word)
        W_OSC:   rd_d = osc_q;
        W_CTRL:  begin
          rd_d[CTL_LED]   = led_o;
          rd_d[CTL_REMAP] = remap_o;
        end
        W_LOCK:  rd_d = {{(DATA_W-17){1'b0}}, unlocked, guard_q};
        W_AUX:   rd_d = aux_q;
        W_SDRAM: rd_d = sdram_q;
        W_INIT:  rd_d = init_q;
        W_FLG:   rd_d = flags_q;
        W_NVF:   rd_d = nvflags_q;
        W_ISTAT: rd_d = level & irq_en_q;
        W_IRAW:  rd_d = level;
        W_IEN:   rd_d = irq_en_q;
        W_SOFT:  rd_d = {{(DATA_W-1){1'b0}}, soft_q};
        W_FSTAT: rd_d = level & fiq_en_q;
        W_FRAW:  rd_d = level;
        W_FEN:   rd_d = fiq_en_q;
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/cm_regbank_chk.sv
module cm_regbank_chk
  import cm_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_ni,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              soft_rst_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [DATA_W-1:0] osc_q,
  input logic [DATA_W-1:0] flags_q,
  input logic [15:0]       guard_q,
  input logic              soft_q,
  input logic [DATA_W-1:0] irq_en_q,
  input logic [DATA_W-1:0] fiq_en_q
);
  // R3
  osc_guarded_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(osc_q) |-> $past(guard_q == GUARD_KEY));

  // R5
  rst_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst_o |-> $past(bus_wr && !bus_addr[ADDR_W-1] &&
                         bus_addr[WORD_W-1:0] == W_CTRL && bus_wdata[CTL_RESET]));

  // R5
  ctrl_bit3_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(bus_rd && !bus_addr[ADDR_W-1] && bus_addr[WORD_W-1:0] == W_CTRL)
      |-> !bus_rdata[CTL_RESET]);

  // R2
  guard_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(bus_rd && !bus_addr[ADDR_W-1] && bus_addr[WORD_W-1:0] == W_LOCK)
      |-> bus_rdata[16] == $past(guard_q == GUARD_KEY));

  // R6
  flag_set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(bus_wr && !bus_addr[ADDR_W-1] && bus_addr[WORD_W-1:0] == W_FLG)
      |-> (flags_q & $past(bus_wdata)) == $past(bus_wdata));

  // R10
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o == $past(soft_q & irq_en_q[0]));

  // R10
  fiq_delay_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    fiq_o == $past(soft_q & fiq_en_q[0]));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

bind cm_regbank cm_regbank_chk u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .soft_rst_o(soft_rst_o), .irq_o(irq_o), .fiq_o(fiq_o),
  .osc_q(osc_q), .flags_q(flags_q), .guard_q(guard_q), .soft_q(soft_q),
  .irq_en_q(irq_en_q), .fiq_en_q(fiq_en_q)
);

// File: tb/test_cm_regbank.sv
module test_cm_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        soft_rst_o, remap_o, led_o, irq_o, fiq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic pend_p = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  cm_regbank #(.MEM_MB(128)) i_cm_regbank (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .soft_rst_o(soft_rst_o), .remap_o(remap_o), .led_o(led_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) pend_p <= bus_rd;

  always @(negedge clk) begin
    if (pend_p) begin
      if (exp_q.size() == 0) begin
        check("R13 unexpected read data", bus_rdata, 32'h0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check("R1 outputs after reset", {27'b0, soft_rst_o, remap_o, led_o, irq_o, fiq_o}, 32'h0);
    rd(7'd0,  32'h0100_0048, "R1 clock word");
    rd(7'd7,  32'h0007_FEFF, "R1 aux clock word");
    rd(7'd8,  32'h0001_1122, "R1 memory timing");
    rd(7'd9,  32'h0000_0112, "R1 memory init");
    rd(7'd5,  32'h0,         "R1 guard");
    rd(7'd12, 32'h0,         "R1 flags");

    // R3: locked write ignored
    wr(7'd0, 32'hDEAD_BEEF);
    rd(7'd0, 32'h0100_0048, "R3 locked clock write ignored");
    wr(7'd7, 32'h1111_1111);
    rd(7'd7, 32'h0007_FEFF, "R3 locked aux write ignored");
    wr(7'd8, 32'h0000_ABCD);
    rd(7'd8, 32'h0000_ABCD, "R3 memory timing always writable");
    wr(7'd9, 32'h0000_0777);
    rd(7'd9, 32'h0000_0777, "R3 memory init always writable");

    // R2: guard keeps low 16 bits, bit 16 flags the key
    wr(7'd5, 32'h1234_A05F);
    rd(7'd5, 32'h0001_A05F, "R2 guard open");
    wr(7'd0, 32'hCAFE_0001);
    rd(7'd0, 32'hCAFE_0001, "R3 unlocked clock write");
    wr(7'd7, 32'h0000_00AA);
    rd(7'd7, 32'h0000_00AA, "R3 unlocked aux write");
    wr(7'd5, 32'hA05F_0000);
    rd(7'd5, 32'h0, "R2 guard closed");
    wr(7'd0, 32'h0);
    rd(7'd0, 32'hCAFE_0001, "R3 relocked write ignored");

    // R4 / R5 control word
    wr(7'd3, 32'hFFFF_FFFF);
    check("R5 reset pulse high", {31'b0, soft_rst_o}, 32'h1);
    @(negedge clk);
    check("R5 reset pulse one cycle", {31'b0, soft_rst_o}, 32'h0);
    check("R4 remap and led", {30'b0, remap_o, led_o}, 32'h3);
    rd(7'd3, 32'h5, "R4 control readback");
    wr(7'd3, 32'h4);
    check("R5 no pulse without bit3", {31'b0, soft_rst_o}, 32'h0);
    check("R4 led cleared", {30'b0, remap_o, led_o}, 32'h2);
    wr(7'd3, 32'h0);
    check("R4 remap cleared", {30'b0, remap_o, led_o}, 32'h0);

    // R6 flags
    wr(7'd12, 32'h0000_00F0);
    wr(7'd12, 32'h0001_0000);
    wr(7'd13, 32'h0000_0030);
    rd(7'd12, 32'h0001_00C0, "R6 flags set/clear");
    wr(7'd14, 32'h8000_000F);
    wr(7'd15, 32'h0000_0005);
    rd(7'd14, 32'h8000_000A, "R6 nv flags set/clear");
    rd(7'd12, 32'h0001_00C0, "R6 flags untouched by nv");

    // R7 enables
    wr(7'd18, 32'h0000_0003);
    wr(7'd19, 32'h0000_0002);
    rd(7'd18, 32'h1, "R7 irq mask");
    wr(7'd26, 32'h0000_0101);
    rd(7'd26, 32'h101, "R7 fiq mask");

    // R8 soft bit, other bits ignored
    wr(7'd20, 32'hFFFF_FFFE);
    rd(7'd20, 32'h0, "R8 upper bits ignored");
    @(negedge clk);
    check("R10 idle irq", {30'b0, irq_o, fiq_o}, 32'h0);
    wr(7'd20, 32'h1);
    check("R10 irq not yet", {30'b0, irq_o, fiq_o}, 32'h0);
    @(negedge clk);
    check("R10 irq and fiq raised", {30'b0, irq_o, fiq_o}, 32'h3);
    rd(7'd20, 32'h1, "R8 soft level");
    rd(7'd17, 32'h1, "R8 irq raw");
    rd(7'd25, 32'h1, "R8 fiq raw");
    rd(7'd16, 32'h1, "R9 irq status");
    rd(7'd24, 32'h1, "R9 fiq status");
    wr(7'd19, 32'h1);
    @(negedge clk);
    check("R10 irq masked off", {30'b0, irq_o, fiq_o}, 32'h1);
    rd(7'd16, 32'h0, "R9 irq status masked");
    wr(7'd21, 32'hFFFF_FFFE);
    rd(7'd20, 32'h1, "R8 clear without bit0 ignored");
    wr(7'd21, 32'h1);
    @(negedge clk);
    check("R10 fiq dropped", {30'b0, irq_o, fiq_o}, 32'h0);
    rd(7'd24, 32'h0, "R9 fiq status after clear");

    // R11 table window
    rd(7'h40, 32'd128, "R11 table byte 0");
    rd(7'h41, 32'd8,   "R11 table byte 1");
    rd(7'h4A, 32'hA0,  "R11 table byte 10");
    rd(7'h5F, 32'd32,  "R11 size byte for 128 MB");
    rd(7'h60, 32'd0,   "R11 table byte 32");
    wr(7'h40, 32'hFFFF_FFFF);
    rd(7'h40, 32'd128, "R11 table write ignored");
    rd(7'd0,  32'hCAFE_0001, "R11 table write leaves word 0");

    // R12 unmapped
    wr(7'd33, 32'hFFFF_FFFF);
    rd(7'd33, 32'h0, "R12 voltage word reads zero");
    wr(7'd1, 32'hFFFF_FFFF);
    rd(7'd1, 32'h0, "R12 word 1 reads zero");
    rd(7'd12, 32'h0001_00C0, "R12 flags untouched");
    rd(7'd18, 32'h0, "R12 irq mask untouched");

    repeat (3) @(negedge clk);
    check("R13 all reads returned", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule